// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresher

This block sits beside a DRAM memory controller and watches the stream of row-close (precharge) events. For every event it makes one independent random trial. With a small programmable probability the trial succeeds. It then asks the controller to activate exactly one of the two rows physically next to the row that just closed. That activation refreshes the neighbour before repeated hammering of the closed row can disturb its cells. When a trial fails, nothing is issued. The block keeps no per-row history. All protection comes from the biased draw and a second, fair draw that picks the side.

The probability is an unsigned fraction supplied on a port. A typical setting is about one in a thousand. The random bits come from an internal maximal-length linear feedback shift register. That register advances once for each close event, whatever the outcome of the trial. A successful draw becomes a request that leaves through a valid/ready handshake. A small FIFO absorbs successes that arrive while an earlier request is still waiting. A success that finds no room is dropped and flagged with a one-cycle overflow pulse.

The output stage is a two-state machine. `ISS_IDLE` has no request on the port. It moves to `ISS_OFFER` (transition "load") as soon as the FIFO holds an entry. `ISS_OFFER` presents a request. On an accepted handshake it either reloads from the FIFO and stays (transition "chain"), or returns to `ISS_IDLE` when the FIFO is empty (transition "drain"). Without ready it stays put (transition "stall").

Top module: `adj_row_refresher`

## Requirements
- R1: After reset, `act_valid` and `overflow` are 0.
- R2: The generator is a 24-bit shift register seeded with 0x5A5A01. On each cycle with `close_valid` high it shifts left by one, and the new bit 0 is the XOR of bits 23, 22, 21 and 16. Each trial uses the value held before that shift. The register never steps on cycles without a close event, and it does step when a draw is dropped.
- R3: A trial succeeds exactly when bits 15..0 of the generator value, read as an unsigned number, are less than `prob_frac`. With `prob_frac` = 0, no trial ever succeeds.
- R4: On success the request names the same bank as the close event. For an interior row, the requested row is `close_row`+1 when generator bit 23 is 1, and `close_row`-1 when it is 0.
- R5: Closing row 0 always yields row 1. Closing the last row (ROWS-1, with 32768 rows by default) always yields row ROWS-2, whatever bit 23 holds.
- R6: A failed trial produces no request and no overflow pulse.
- R7: While `act_valid` is high and `act_ready` is low, `act_valid`, `act_bank` and `act_row` hold their values. Every accepted success is delivered exactly once, in the order of its close events.
- R8: With `act_ready` held low, up to FIFO_DEPTH+1 (5 by default) successes can be outstanding. Any further success is discarded, and `overflow` is high for one cycle, the cycle after its close event.
- R9: `overflow` is never high unless a successful trial was discarded in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_valid | input | 1 | A row-close event is present this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Index of the closed row |
| prob_frac | input | PROB_W | Success probability as an unsigned fraction of 2^PROB_W |
| act_valid | output | 1 | A neighbour activation request is offered |
| act_ready | input | 1 | Controller accepts the offered request |
| act_bank | output | BANK_W | Bank of the neighbour row |
| act_row | output | ROW_W | Neighbour row to activate |
| overflow | output | 1 | One-cycle pulse: a successful draw was discarded |

## Verification
The hardest situation to reach from the ports is a discarded success. It needs a full FIFO, a full output slot and one more winning draw, all at the same time, and at realistic probabilities that almost never happens. The stimulus holds `act_ready` low and sets `prob_frac` to its maximum, so nearly every draw wins. It then issues back-to-back close events until the model predicts drops, and compares the overflow pulses with that prediction. Afterwards it drains the queue and keeps drawing, which shows that the generator also stepped on the discarded events.

// File: rtl/arr_pkg.sv
package arr_pkg;

    // Output stage states
    typedef enum logic [0:0] {
        ISS_IDLE  = 1'b0,
        ISS_OFFER = 1'b1
    } iss_state_t;

    // Side picked by the fair draw
    typedef enum logic [0:0] {
        SIDE_BELOW = 1'b0,
        SIDE_ABOVE = 1'b1
    } nbr_side_t;

endpackage

// File: rtl/arr_lfsr.sv
module arr_lfsr #(
    parameter int              W    = 24,
    parameter logic [W-1:0]    TAPS = 24'hE10000,
    parameter logic [W-1:0]    SEED = 24'h5A5A01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;
    logic         feedback;

    assign feedback = ^(state_q & TAPS);
    assign value    = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end

    // R2: a maximal-length register never reaches the all-zero lock-up state
    a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R2: the generator only moves when a close event is present
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/arr_draw.sv
module arr_draw
    import arr_pkg::*;
#(
    parameter int LFSR_W = 24,
    parameter int PROB_W = 16,
    parameter int ROW_W  = 15,
    parameter int ROWS   = 32768
) (
    input  logic [LFSR_W-1:0] rnd,
    input  logic [PROB_W-1:0] prob,
    input  logic [ROW_W-1:0]  row,
    output logic              hit,
    output logic [ROW_W-1:0]  nbr_row
);

    localparam int              PICK_BIT = LFSR_W - 1;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [ROW_W-1:0] ONE      = ROW_W'(1);

    nbr_side_t side;

    // Biased draw: low bits compared against the fraction
    assign hit = (rnd[PROB_W-1:0] < prob);

    // Fair draw: a bit outside the compared field picks the side
    always_comb begin
        if (row == '0) begin
            side = SIDE_ABOVE;
        end else if (row == LAST_ROW) begin
            side = SIDE_BELOW;
        end else begin
            side = rnd[PICK_BIT] ? SIDE_ABOVE : SIDE_BELOW;
        end
    end

    always_comb begin
        unique case (side)
            SIDE_ABOVE: nbr_row = row + ONE;
            SIDE_BELOW: nbr_row = row - ONE;
            default:    nbr_row = row;
        endcase
    end

endmodule

// File: rtl/arr_fifo.sv
module arr_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_FULL);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PW'(1);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R8: the upstream gating never writes into a full buffer without a read
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R7: the output stage only reads an entry that exists
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8: occupancy stays within the configured depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);

endmodule

// File: rtl/arr_issuer.sv
module arr_issuer
    import arr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_dout,
    output logic         fifo_pop,
    output logic         req_valid,
    input  logic         req_ready,
    output logic [W-1:0] req_data
);

    iss_state_t state_q;
    iss_state_t state_d;
    logic [W-1:0] data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and pop decision
    always_comb begin
        state_d  = state_q;
        fifo_pop = 1'b0;
        unique case (state_q)
            ISS_IDLE: begin
                if (!fifo_empty) begin          // load
                    fifo_pop = 1'b1;
                    state_d  = ISS_OFFER;
                end
            end
            ISS_OFFER: begin
                if (req_ready) begin
                    if (!fifo_empty) begin      // chain
                        fifo_pop = 1'b1;
                        state_d  = ISS_OFFER;
                    end else begin              // drain
                        state_d  = ISS_IDLE;
                    end
                end                             // stall otherwise
            end
            default: state_d = ISS_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (fifo_pop) begin
            data_q <= fifo_dout;
        end
    end

    assign req_valid = (state_q == ISS_OFFER);
    assign req_data  = data_q;

    // R7: an offered request is held until it is taken
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));

endmodule

// File: rtl/adj_row_refresher.sv
module adj_row_refresher #(
    parameter int           BANK_W     = 3,
    parameter int           ROW_W      = 15,
    parameter int           ROWS       = 32768,
    parameter int           PROB_W     = 16,
    parameter int           LFSR_W     = 24,
    parameter logic [23:0]  LFSR_TAPS  = 24'hE10000,
    parameter logic [23:0]  LFSR_SEED  = 24'h5A5A01,
    parameter int           FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_valid,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [ROW_W-1:0]  close_row,
    input  logic [PROB_W-1:0] prob_frac,
    output logic              act_valid,
    input  logic              act_ready,
    output logic [BANK_W-1:0] act_bank,
    output logic [ROW_W-1:0]  act_row,
    output logic              overflow
);

    localparam int ENTRY_W = BANK_W + ROW_W;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [LFSR_W-1:0]  rnd;
    logic               hit;
    logic [ROW_W-1:0]   nbr_row;
    logic               fifo_push;
    logic               fifo_pop;
    logic               fifo_empty;
    logic               fifo_full;
    logic [ENTRY_W-1:0] fifo_dout;
    logic [ENTRY_W-1:0] req_data;
    logic               win;
    logic               room;
    logic               overflow_q;

    arr_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS[LFSR_W-1:0]),
        .SEED (LFSR_SEED[LFSR_W-1:0])
    ) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (close_valid),
        .value (rnd)
    );

    arr_draw #(
        .LFSR_W (LFSR_W),
        .PROB_W (PROB_W),
        .ROW_W  (ROW_W),
        .ROWS   (ROWS)
    ) i_draw (
        .rnd     (rnd),
        .prob    (prob_frac),
        .row     (close_row),
        .hit     (hit),
        .nbr_row (nbr_row)
    );

    assign win       = close_valid && hit;
    assign room      = !fifo_full || fifo_pop;
    assign fifo_push = win && room;

    arr_fifo #(
        .W     (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   ({close_bank, nbr_row}),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    arr_issuer #(
        .W (ENTRY_W)
    ) i_issuer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (fifo_pop),
        .req_valid  (act_valid),
        .req_ready  (act_ready),
        .req_data   (req_data)
    );

    assign act_bank = req_data[ENTRY_W-1:ROW_W];
    assign act_row  = req_data[ROW_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow_q <= 1'b0;
        end else begin
            overflow_q <= win && !room;
        end
    end

    assign overflow = overflow_q;

    // R3: a zero fraction never wins a draw
    a_r3_zero_prob: assert property (@(posedge clk) disable iff (!rst_n)
        (close_valid && prob_frac == '0) |-> !hit);

    // R4: a winning draw names a row at distance one
    a_r4_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (nbr_row == close_row + ROW_W'(1) || nbr_row == close_row - ROW_W'(1)));

    // R5: edge rows only have one neighbour
    a_r5_first_row: assert property (@(posedge clk) disable iff (!rst_n)
        (win && close_row == '0) |-> nbr_row == ROW_W'(1));

    a_r5_last_row: assert property (@(posedge clk) disable iff (!rst_n)
        (win && close_row == LAST_ROW) |-> nbr_row == LAST_ROW - ROW_W'(1));

    // R9: an overflow pulse follows a winning close event that found no room
    a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_q |-> $past(win && fifo_full));

    // R8: the pulse lasts one cycle unless another drop follows
    a_r8_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_q) |-> $past(close_valid));

endmodule

// File: tb/test_adj_row_refresher.sv
module test_adj_row_refresher;

    localparam int BANK_W = 3;
    localparam int ROW_W  = 15;
    localparam int ROWS   = 32768;
    localparam int PROB_W = 16;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              close_valid = 1'b0;
    logic [BANK_W-1:0] close_bank = '0;
    logic [ROW_W-1:0]  close_row = '0;
    logic [PROB_W-1:0] prob_frac = '0;
    logic              act_valid;
    logic              act_ready = 1'b0;
    logic [BANK_W-1:0] act_bank;
    logic [ROW_W-1:0]  act_row;
    logic              overflow;

    int vectors = 0;
    int miscompares = 0;
    int seen_ovf = 0;
    int exp_drops = 0;
    int cyc = 0;
    bit drop_mode = 1'b0;
    bit auto_ready = 1'b0;
    bit done = 1'b0;
    bit hold_pending = 1'b0;
    logic [BANK_W+ROW_W-1:0] held;

    logic [23:0] m_lfsr = 24'h5A5A01;
    logic [BANK_W+ROW_W-1:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    adj_row_refresher i_adj_row_refresher (
        .clk         (clk),
        .rst_n       (rst_n),
        .close_valid (close_valid),
        .close_bank  (close_bank),
        .close_row   (close_row),
        .prob_frac   (prob_frac),
        .act_valid   (act_valid),
        .act_ready   (act_ready),
        .act_bank    (act_bank),
        .act_row     (act_row),
        .overflow    (overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one close event per call, expected item pushed from the model
    task automatic send(input int bank, input int row);
        logic [ROW_W-1:0] nbr;
        bit win;
        @(negedge clk); #2;
        close_valid = 1'b1;
        close_bank  = BANK_W'(bank);
        close_row   = ROW_W'(row);
        win = (m_lfsr[15:0] < prob_frac);                     // R3
        if (win) begin
            if (row == 0) nbr = ROW_W'(1);                    // R5
            else if (row == ROWS - 1) nbr = ROW_W'(ROWS - 2); // R5
            else if (m_lfsr[23]) nbr = ROW_W'(row + 1);       // R4
            else nbr = ROW_W'(row - 1);
            if (drop_mode && exp_q.size() == DEPTH + 1) begin
                exp_drops++;                                   // R8
            end else begin
                exp_q.push_back({BANK_W'(bank), nbr});
                tag_q.push_back((row == 0 || row == ROWS - 1) ? "R5" : "R4");
            end
        end
        // R2: model step, taps 23,22,21,16
        m_lfsr = {m_lfsr[22:0], m_lfsr[23] ^ m_lfsr[22] ^ m_lfsr[21] ^ m_lfsr[16]};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            close_valid = 1'b0;
        end
    endtask

    always begin
        @(negedge clk); #2;
        cyc++;
        if (auto_ready) act_ready = (cyc % 3 != 0);
    end

    // Monitor: samples 2 ns before each rising edge
    always begin
        @(negedge clk); #8;
        if (rst_n) begin
            if (overflow) begin
                seen_ovf++;
                if (!drop_mode) check(1'b0, "R9", "overflow without drop", 1, 0);
            end
            if (hold_pending) begin
                check(act_valid && {act_bank, act_row} == held, "R7",
                      "payload held under back-pressure", {act_valid, act_bank, act_row}, {1'b1, held});
            end
            if (act_valid && act_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected request", {act_bank, act_row}, 0);
                end else begin
                    logic [BANK_W+ROW_W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({act_bank, act_row} == e, t, "neighbour request", {act_bank, act_row}, e);
                end
            end
            hold_pending = act_valid && !act_ready;
            held = {act_bank, act_row};
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #8;
        // R1: reset state
        check(act_valid == 1'b0, "R1", "valid in reset", act_valid, 0);
        check(overflow == 1'b0, "R1", "overflow in reset", overflow, 0);
        @(negedge clk); #2;
        rst_n = 1'b1;
        idle(2);
        #6;
        check(act_valid == 1'b0 && overflow == 1'b0, "R1", "outputs after reset",
              {act_valid, overflow}, 0);

        // R3/R6: zero fraction never requests
        act_ready = 1'b1;
        prob_frac = '0;
        for (int i = 0; i < 20; i++) send(i % 8, 1000 + i);
        idle(6);
        #6;
        check(act_valid == 1'b0, "R6", "no request at zero fraction", act_valid, 0);
        check(exp_q.size() == 0, "R3", "model expects none", exp_q.size(), 0);

        // R4/R5: near-certain wins, edges and interior rows
        prob_frac = '1;
        send(5, 0);            idle(3);
        send(2, ROWS - 1);     idle(3);
        send(7, 0);            idle(3);
        send(1, ROWS - 1);     idle(3);
        for (int i = 0; i < 16; i++) begin
            send(i % 8, 4000 + 37 * i);
            idle(2);
        end
        idle(6);
        #6;
        check(exp_q.size() == 0, "R7", "all edge/interior requests delivered", exp_q.size(), 0);

        // R7: half probability with intermittent ready
        prob_frac = 16'h8000;
        auto_ready = 1'b1;
        for (int i = 0; i < 60; i++) begin
            send(i % 8, 200 + 13 * i);
            idle(2);
        end
        auto_ready = 1'b0;
        @(negedge clk); #2;
        act_ready = 1'b1;
        idle(10);
        #6;
        check(exp_q.size() == 0, "R7", "ordered delivery with back-pressure", exp_q.size(), 0);

        // R3: low probability over many back-to-back events
        prob_frac = 16'h0400;
        for (int i = 0; i < 300; i++) send(i % 8, 9000 + i);
        idle(10);
        #6;
        check(exp_q.size() == 0, "R3", "low-probability draws", exp_q.size(), 0);

        // R8: fill buffer with ready low and force drops
        @(negedge clk); #2;
        act_ready = 1'b0;
        drop_mode = 1'b1;
        seen_ovf  = 0;
        exp_drops = 0;
        prob_frac = '1;
        for (int i = 0; i < 9; i++) send(3, 20000 + 5 * i);
        idle(4);
        #6;
        check(exp_drops > 0, "R8", "stimulus reached overflow", exp_drops, 1);
        check(seen_ovf == exp_drops, "R8", "overflow pulse count", seen_ovf, exp_drops);
        check(act_valid == 1'b1, "R8", "request waiting while full", act_valid, 1);
        check(exp_q.size() == DEPTH + 1, "R8", "outstanding capacity", exp_q.size(), DEPTH + 1);
        @(negedge clk); #2;
        drop_mode = 1'b0;
        act_ready = 1'b1;
        idle(10);
        #6;
        check(exp_q.size() == 0, "R8", "buffered requests drained", exp_q.size(), 0);

        // R2: generator stepped on dropped events too
        for (int i = 0; i < 12; i++) begin
            send(6, 30000 + 3 * i);
            idle(1);
        end
        idle(6);
        #6;
        check(exp_q.size() == 0, "R2", "sequence continues after drops", exp_q.size(), 0);
        check(act_valid == 1'b0, "R6", "idle at end", act_valid, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule